// File: doc/BRIEF.md
# Programmable Output Clock Divider

This block turns a fast source clock into one output clock. Each of six stored configuration sets holds a one-bit mode flag and a seven-bit divide code. An external select input picks the set that is in use. A non-reserved code gives either a fixed divide-by-two or a programmable even ratio of (code+2)*2. The reserved all-ones code either stops the divider or passes the source clock straight through, depending on the mode flag.

An output-enable pin and a two-bit park mode decide what the output does while it is not enabled. It can be flagged high-impedance, held low or held high. An invert control flips the running clock, but the park levels are applied after the inversion, so a parked pin always shows the encoded level. The block takes in a new set or a new code only at a rising edge of the divided clock, so a change never produces a short pulse.

Top module: `outclk_divider`

## Requirements
- R1: While reset is held, the divided output is low and not flagged high-impedance (enabled, no inversion). After release, in a dividing mode with half-period H source cycles, the output is high after source edge n exactly when floor(n/H) is odd.
- R2: With mode flag 0 and a code other than 7'h7F, the output toggles on every source rising edge (divide by 2).
- R3: With mode flag 1 and a code Q other than 7'h7F, the output period is (Q+2)*2 source cycles, with Q+2 cycles high and Q+2 cycles low.
- R4: With mode flag 0 and code 7'h7F, the divider is stopped and the output holds low, or high when inverted.
- R5: With mode flag 1 and code 7'h7F, the output follows the source clock level, or its complement when inverted.
- R6: Set i takes its mode flag from bit i of the mode vector and its code from bits [7i+6:7i] of the code vector. Select values 0 to 5 pick that set, and select values 6 and 7 pick set 0.
- R7: A change of select or of the active set's settings made while dividing takes effect at the next rising edge of the divided output. The running half-period completes with the old ratio.
- R8: When the enable pin is low and park mode bit 0 is 0 (codes 00 and 10), the high-impedance flag is 1 and the output is low.
- R9: When the enable pin is low, park mode 01 holds the output low and 11 holds it high, with the high-impedance flag at 0, whatever the invert setting.
- R10: With the enable pin high, an invert setting of 1 gives the complement of the divided clock, and the high-impedance flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel | input | 3 | Configuration set select |
| cfg_mode_bits | input | 6 | Mode flag of each set, bit i for set i |
| cfg_codes | input | 42 | Divide code of each set, 7 bits per set |
| oe_mode | input | 2 | Park behaviour while disabled |
| invert_en | input | 1 | Invert the running clock |
| oe_pin | input | 1 | Output enable, active high |
| clk_out | output | 1 | Divided clock or park level |
| out_hiz | output | 1 | Output is to be high-impedance |

## Verification
The assertions take the configuration inputs as quasi-static. They may change at any time, but the select only has to resolve to a set within one source cycle. The bench changes every input half a source cycle away from the rising edge and keeps them steady while reset is applied. Each ratio is measured from a fresh reset, and the deferred-update case deliberately changes the code in the middle of a half-period. The bypass path is checked by sampling both levels of the source clock, not at its edges.

// File: rtl/outdiv_pkg.sv
// Shared types and helpers for the output clock divider.
// Assumes a seven-bit divide code whose all-ones value is reserved.
package outdiv_pkg;
    localparam int CODE_W = 7;
    localparam int HALF_W = CODE_W + 1;

    typedef struct packed {
        logic              mode;
        logic [CODE_W-1:0] code;
    } div_cfg_t;

    typedef enum logic [1:0] {
        DIV_FIXED2 = 2'd0,
        DIV_PROG   = 2'd1,
        DIV_OFF    = 2'd2,
        DIV_BYPASS = 2'd3
    } div_kind_t;

    // Decode a set into its kind of operation.
    function automatic div_kind_t classify(input div_cfg_t c);
        if (&c.code) return c.mode ? DIV_BYPASS : DIV_OFF;
        return c.mode ? DIV_PROG : DIV_FIXED2;
    endfunction

    // Source cycles per half output period for the dividing kinds.
    function automatic logic [HALF_W-1:0] half_of(input div_cfg_t c);
        if (c.mode) return HALF_W'(c.code) + HALF_W'(2);
        return HALF_W'(1);
    endfunction
endpackage

// File: rtl/outdiv_cfg_mux.sv
// Picks one of NUM_SETS stored configuration sets.
// Assumes set i sits at bit i of the mode vector and slice i of the codes.
// An out-of-range select falls back to set 0.
module outdiv_cfg_mux
    import outdiv_pkg::*;
#(
    parameter int NUM_SETS = 6,
    parameter int SEL_W    = 3
) (
    input  logic [SEL_W-1:0]           sel,
    input  logic [NUM_SETS-1:0]        mode_bits,
    input  logic [NUM_SETS*CODE_W-1:0] codes,
    output div_cfg_t                   cfg
);
    div_cfg_t sets [NUM_SETS];

    for (genvar gi = 0; gi < NUM_SETS; gi++) begin : g_unpack
        assign sets[gi] = '{mode: mode_bits[gi], code: codes[gi*CODE_W +: CODE_W]};
    end

    // Select the addressed set, defaulting to set 0.
    always_comb begin
        cfg = sets[0];
        for (int i = 1; i < NUM_SETS; i++) begin
            if (sel == SEL_W'(i)) cfg = sets[i];
        end
    end
endmodule

// File: rtl/outdiv_core.sv
// Half-period counter and toggle register. Holds the active settings and
// reloads them only at a rising edge of the divided clock, or on every
// edge while the divider is stopped or bypassed.
// Assumes next_cfg is settled one source cycle before it is used.
module outdiv_core
    import outdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  div_cfg_t next_cfg,
    output logic     div_q,
    output logic     bypass
);
    div_cfg_t          act;
    logic [HALF_W-1:0] cnt;
    div_kind_t         kind;
    logic [HALF_W-1:0] half;
    logic              dividing;
    logic              wrap;
    logic              load;

    // Decode the active settings.
    always_comb begin
        kind     = classify(act);
        half     = half_of(act);
        dividing = (kind == DIV_FIXED2) || (kind == DIV_PROG);
        wrap     = (cnt == half - HALF_W'(1));
        load     = !dividing || (wrap && !div_q);
    end

    // Count half periods, toggle the output and reload the settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act   <= next_cfg;
            cnt   <= '0;
            div_q <= 1'b0;
        end else begin
            if (load) act <= next_cfg;
            if (dividing) begin
                if (wrap) begin
                    cnt   <= '0;
                    div_q <= ~div_q;
                end else begin
                    cnt <= cnt + HALF_W'(1);
                end
            end else begin
                cnt   <= '0;
                div_q <= 1'b0;
            end
        end
    end

    assign bypass = (kind == DIV_BYPASS);

    // Marks the cycles after the first edge out of reset.
    logic run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dividing |-> (cnt < half));

    // R4
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == DIV_OFF) |=> !div_q);

    // R5
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == DIV_BYPASS) |=> (!div_q && cnt == '0));

    // R7
    settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !$stable(act) && $past(dividing)) |-> $rose(div_q));
endmodule

// File: rtl/outdiv_pad.sv
// Output stage: selects the divided or source clock, applies inversion,
// then the park level or high-impedance flag while disabled.
// Assumes park mode 00/10 = high-impedance, 01 = low, 11 = high.
module outdiv_pad (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       div_q,
    input  logic       bypass,
    input  logic       invert_en,
    input  logic       oe_pin,
    input  logic [1:0] oe_mode,
    output logic       clk_out,
    output logic       out_hiz
);
    logic run_clk;

    // Form the running clock and apply the enable and park rules.
    always_comb begin
        run_clk = (bypass ? clk : div_q) ^ invert_en;
        if (oe_pin) begin
            clk_out = run_clk;
            out_hiz = 1'b0;
        end else if (!oe_mode[0]) begin
            clk_out = 1'b0;
            out_hiz = 1'b1;
        end else begin
            clk_out = oe_mode[1];
            out_hiz = 1'b0;
        end
    end

    // R9
    park_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_pin && oe_mode[0]) |-> (!out_hiz && clk_out == oe_mode[1]));

    // R8
    hiz_only_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hiz |-> (!oe_pin && !oe_mode[0] && !clk_out));
endmodule

// File: rtl/outclk_divider.sv
// Programmable output clock divider with six selectable configuration sets.
// Assumes all inputs are synchronous to clk.
module outclk_divider
    import outdiv_pkg::*;
#(
    parameter int NUM_SETS = 6,
    localparam int SEL_W   = $clog2(NUM_SETS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SEL_W-1:0]           cfg_sel,
    input  logic [NUM_SETS-1:0]        cfg_mode_bits,
    input  logic [NUM_SETS*CODE_W-1:0] cfg_codes,
    input  logic [1:0]                 oe_mode,
    input  logic                       invert_en,
    input  logic                       oe_pin,
    output logic                       clk_out,
    output logic                       out_hiz
);
    div_cfg_t next_cfg;
    logic     div_q;
    logic     bypass;

    outdiv_cfg_mux #(.NUM_SETS(NUM_SETS), .SEL_W(SEL_W)) u_mux (
        .sel       (cfg_sel),
        .mode_bits (cfg_mode_bits),
        .codes     (cfg_codes),
        .cfg       (next_cfg)
    );

    outdiv_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .next_cfg (next_cfg),
        .div_q    (div_q),
        .bypass   (bypass)
    );

    outdiv_pad u_pad (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_q     (div_q),
        .bypass    (bypass),
        .invert_en (invert_en),
        .oe_pin    (oe_pin),
        .oe_mode   (oe_mode),
        .clk_out   (clk_out),
        .out_hiz   (out_hiz)
    );
endmodule

// File: tb/tb_outclk_divider.sv
module tb_outclk_divider;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  sel;
    logic [5:0]  modes;
    logic [41:0] codes;
    logic [1:0]  oem;
    logic        inv;
    logic        oe;
    logic        clk_out;
    logic        hiz;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #10 clk = ~clk;

    outclk_divider dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(sel), .cfg_mode_bits(modes),
        .cfg_codes(codes), .oe_mode(oem), .invert_en(inv), .oe_pin(oe),
        .clk_out(clk_out), .out_hiz(hiz)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input int idx, input logic m, input logic [6:0] q);
        modes[idx] = m;
        codes[idx*7 +: 7] = q;
    endtask

    // Ends just after a negedge with reset released; next posedge is edge 1.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_div(input string req, input int half, input int nedges, input logic ix);
        for (int n = 1; n <= nedges; n++) begin
            @(posedge clk);
            @(negedge clk);
            #2;
            chk(req, clk_out, logic'((n / half) % 2) ^ ix);
            chk(req, hiz, 1'b0);
        end
    endtask

    initial begin
        rst_n = 1'b0; sel = 3'd0; modes = '0; codes = '0;
        oem = 2'b00; inv = 1'b0; oe = 1'b1;

        // R1: reset state, then first rise after H edges
        set_cfg(0, 1'b1, 7'd3);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #2;
        chk("R1", clk_out, 1'b0);
        chk("R1", hiz, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        run_div("R1", 5, 20, 1'b0);

        // R2: fixed divide by two for several codes
        foreach (codes[i]) ;
        for (int q = 0; q < 127; q += 42) begin
            set_cfg(0, 1'b0, 7'(q));
            do_reset();
            run_div("R2", 1, 8, 1'b0);
        end

        // R3: sweep every programmable code
        for (int q = 0; q < 127; q++) begin
            set_cfg(0, 1'b1, 7'(q));
            do_reset();
            run_div("R3", q + 2, 4 * (q + 2), 1'b0);
        end

        // R10: inversion of a running clock
        inv = 1'b1;
        set_cfg(0, 1'b1, 7'd1);
        do_reset();
        run_div("R10", 3, 12, 1'b1);
        inv = 1'b0;

        // R4: stopped divider, plain and inverted
        for (int ix = 0; ix < 2; ix++) begin
            inv = 1'(ix);
            set_cfg(0, 1'b0, 7'h7F);
            do_reset();
            for (int n = 0; n < 20; n++) begin
                @(negedge clk); #2;
                chk("R4", clk_out, 1'(ix));
            end
        end

        // R5: bypass follows the source clock
        for (int ix = 0; ix < 2; ix++) begin
            inv = 1'(ix);
            set_cfg(0, 1'b1, 7'h7F);
            do_reset();
            for (int n = 0; n < 10; n++) begin
                @(posedge clk); #5;
                chk("R5", clk_out, 1'b1 ^ 1'(ix));
                @(negedge clk); #5;
                chk("R5", clk_out, 1'b0 ^ 1'(ix));
            end
        end
        inv = 1'b0;

        // R6: each set gives its own ratio; out-of-range selects fall to set 0
        for (int i = 0; i < 6; i++) set_cfg(i, 1'b1, 7'(i));
        for (int s = 0; s < 8; s++) begin
            sel = 3'(s);
            do_reset();
            run_div("R6", (s < 6) ? s + 2 : 2, 4 * ((s < 6) ? s + 2 : 2), 1'b0);
        end
        sel = 3'd0;

        // R7: change mid half-period is deferred to the next rising edge
        begin
            logic exp7 [3:8];
            exp7[3] = 1'b0; exp7[4] = 1'b1; exp7[5] = 1'b1;
            exp7[6] = 1'b0; exp7[7] = 1'b0; exp7[8] = 1'b1;
            set_cfg(0, 1'b1, 7'd2);
            do_reset();
            run_div("R7", 4, 2, 1'b0);
            set_cfg(0, 1'b1, 7'd0);
            for (int n = 3; n <= 8; n++) begin
                @(posedge clk); @(negedge clk); #2;
                chk("R7", clk_out, exp7[n]);
            end
        end

        // R8 and R9: park behaviour while disabled, with and without inversion
        set_cfg(0, 1'b1, 7'd0);
        do_reset();
        for (int ix = 0; ix < 2; ix++) begin
            for (int m = 0; m < 4; m++) begin
                @(negedge clk);
                inv = 1'(ix); oem = 2'(m); oe = 1'b0;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk); #2;
                    if (m[0] == 1'b0) begin
                        chk("R8", hiz, 1'b1);
                        chk("R8", clk_out, 1'b0);
                    end else begin
                        chk("R9", hiz, 1'b0);
                        chk("R9", clk_out, 1'(m >> 1));
                    end
                end
            end
        end
        oe = 1'b1; inv = 1'b0; oem = 2'b00;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4_000_000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule